// File: doc/BRIEF.md
# Calibration Pulse and Reverse-Power Indicator

This block turns a stream of signed real-power samples into a fast calibration pulse train and a level output that shows the direction of power flow. Each accepted sample is added to a signed accumulator. When the accumulator reaches plus or minus a threshold, one pulse is issued, the threshold is removed from the accumulator, and the direction of that crossing is copied to the reverse-power output. The threshold is a base value shifted right by a rate-select code. The pulse frequency is therefore the slow-output frequency times a selectable multiplier.

The pulse width is chosen when each pulse is issued. It is a fixed long width. When pulses come close together it becomes half of the measured spacing, and in the high-speed rate setting it is a very short fixed width. All widths are counted in system clocks and derived from the clock-frequency parameter. The sample input is a valid/ready stream. The block never applies back-pressure (ready is always high), so a sample is taken on every clock where valid is high. Supply-good and creep-permit are plain level controls.

Top module: `cal_pulse_gen`

## Requirements
- R0: After reset `cal_pulse` and `rev_flag` are low and `pwr_ready` is high.
- R1: The threshold is BASE_THR >> s, where s is set by {`scale_sel`,`rate_sel`}: 100→7, 000→6, 101→6, 001→5, 110→5, 010→4, 111→4, 011→11. A result of 0 is raised to 1. For positive power, the number of pulses equals the accumulated sum divided by the threshold, rounded down.
- R2: Negative power also issues pulses, one per threshold of negative sum, and each such pulse sets `rev_flag` high.
- R3: `rev_flag` changes only in the cycle a pulse rises (or on supply loss). A pulse from a positive crossing drives it low, and a positive input that does not cross leaves it unchanged.
- R4: When the time since the previous pulse is at least 2·WIDE cycles, or no pulse has occurred since reset or supply loss, the pulse stays high for WIDE = CLK_HZ·90/1000 cycles.
- R5: When the time P since the previous pulse is below 2·WIDE, the pulse stays high for P/2 cycles, rounded down and at least 1.
- R6: In high-speed mode ({`scale_sel`,`rate_sel`} = 011) every pulse stays high for HS = max(1, CLK_HZ·35/1e6) cycles.
- R7: While `supply_ok` is low, `cal_pulse` and `rev_flag` are low one clock later, and the accumulator and the measured spacing are cleared.
- R8: While `creep_ok` is low, samples are discarded and no pulse is issued. The accumulator keeps its value.
- R9: A crossing that occurs while the pulse is high is held until the pulse has been low for one cycle. No crossing is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_data | input | DATA_W | Signed power sample |
| pwr_valid | input | 1 | Sample strobe |
| pwr_ready | output | 1 | Always high; no back-pressure |
| rate_sel | input | 2 | Rate select |
| scale_sel | input | 1 | Calibration scale select |
| supply_ok | input | 1 | Supply-good level |
| creep_ok | input | 1 | Load above no-load threshold |
| cal_pulse | output | 1 | Active-high calibration pulse |
| rev_flag | output | 1 | High when the last pulse came from negative power |

## Verification
A sample that is accepted at a clock edge updates the accumulator at that edge. The threshold compare happens at the next edge, so `cal_pulse` and `rev_flag` change on the second edge after the sample was presented. Loss of supply is seen on the outputs after one edge. The bench drives inputs on the falling edge and steps a behavioural model on every rising edge. It compares that model with the outputs at each falling edge, so every comparison sees the registered results of exactly those edges. The directed checks count pulse rises and measure high-run lengths only after waiting long enough for held crossings to drain.

// File: rtl/cal_pkg.sv
package cal_pkg;
  // right-shift applied to the base threshold for each {scale, rate} code
  function automatic int unsigned rate_shift(input logic scale, input logic [1:0] rate);
    unique case ({scale, rate})
      3'b100:  return 7;
      3'b000:  return 6;
      3'b101:  return 6;
      3'b001:  return 5;
      3'b110:  return 5;
      3'b010:  return 4;
      3'b111:  return 4;
      default: return 11;
    endcase
  endfunction

  function automatic logic is_fast(input logic scale, input logic [1:0] rate);
    return (!scale && rate == 2'b11);
  endfunction
endpackage

// File: rtl/cal_thresh_sel.sv
module cal_thresh_sel
  import cal_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int BASE_THR = 1 << 20
) (
  input  logic             scale_sel,
  input  logic [1:0]       rate_sel,
  output logic [ACC_W-1:0] thr,
  output logic             hs_mode
);
  localparam logic [ACC_W-1:0] BASE = ACC_W'(BASE_THR);
  logic [ACC_W-1:0] shifted;

  always_comb begin
    shifted = BASE >> rate_shift(scale_sel, rate_sel);
    thr     = (shifted == '0) ? ACC_W'(1) : shifted;
    hs_mode = is_fast(scale_sel, rate_sel);
  end
endmodule

// File: rtl/cal_accum.sv
module cal_accum #(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [DATA_W-1:0] sample,
  input  logic              allow,
  input  logic [ACC_W-1:0]  thr,
  output logic              issue,
  output logic              issue_neg
);
  logic signed [ACC_W-1:0] acc_q, thr_s, ext, adj;
  logic pos, neg;

  always_comb begin
    thr_s = $signed(thr);
    ext   = take ? $signed({{(ACC_W-DATA_W){sample[DATA_W-1]}}, sample}) : '0;
    pos   = allow && (acc_q >= thr_s);
    neg   = allow && !pos && (acc_q <= -thr_s);
    adj   = pos ? -thr_s : (neg ? thr_s : '0);
    issue     = pos | neg;
    issue_neg = neg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else          acc_q <= acc_q + ext + adj;
  end
endmodule

// File: rtl/cal_width.sv
module cal_width #(
  parameter int WIDE_CYC = 9000,
  parameter int HS_CYC   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic issue,
  input  logic issue_neg,
  input  logic hs_mode,
  output logic cal_pulse,
  output logic rev_flag
);
  localparam int SAT   = 2 * WIDE_CYC;
  localparam int CNT_W = $clog2(SAT + 1);
  localparam logic [CNT_W-1:0] SAT_V  = CNT_W'(SAT);
  localparam logic [CNT_W-1:0] WIDE_V = CNT_W'(WIDE_CYC);
  localparam logic [CNT_W-1:0] HS_V   = CNT_W'(HS_CYC);

  logic [CNT_W-1:0] per_q, rem_q, width_c, half_c;
  logic pulse_q, rev_q;

  always_comb begin
    half_c = per_q >> 1;
    if (hs_mode)           width_c = HS_V;
    else if (per_q < SAT_V) width_c = (half_c == '0) ? CNT_W'(1) : half_c;
    else                   width_c = WIDE_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= SAT_V; rem_q <= '0; pulse_q <= 1'b0; rev_q <= 1'b0;
    end else if (clr) begin
      per_q <= SAT_V; rem_q <= '0; pulse_q <= 1'b0; rev_q <= 1'b0;
    end else begin
      if (issue) begin
        pulse_q <= 1'b1;
        rem_q   <= width_c - CNT_W'(1);
        rev_q   <= issue_neg;
      end else if (pulse_q) begin
        if (rem_q == '0) pulse_q <= 1'b0;
        else             rem_q   <= rem_q - CNT_W'(1);
      end
      if (issue)             per_q <= CNT_W'(1);
      else if (per_q < SAT_V) per_q <= per_q + CNT_W'(1);
    end
  end

  assign cal_pulse = pulse_q;
  assign rev_flag  = rev_q;
endmodule

// File: rtl/cal_pulse_gen.sv
module cal_pulse_gen #(
  parameter int DATA_W   = 24,
  parameter int ACC_W    = 32,
  parameter int BASE_THR = 1 << 20,
  parameter int CLK_HZ   = 100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pwr_data,
  input  logic              pwr_valid,
  output logic              pwr_ready,
  input  logic [1:0]        rate_sel,
  input  logic              scale_sel,
  input  logic              supply_ok,
  input  logic              creep_ok,
  output logic              cal_pulse,
  output logic              rev_flag
);
  localparam int WIDE_CYC = CLK_HZ / 1000 * 90;
  localparam int HS_RAW   = CLK_HZ / 1000 * 35 / 1000;
  localparam int HS_CYC   = (HS_RAW < 1) ? 1 : HS_RAW;

  logic [ACC_W-1:0] thr;
  logic hs_mode, issue, issue_neg;

  assign pwr_ready = 1'b1;

  cal_thresh_sel #(.ACC_W(ACC_W), .BASE_THR(BASE_THR)) u_thr (
    .scale_sel(scale_sel), .rate_sel(rate_sel), .thr(thr), .hs_mode(hs_mode)
  );

  cal_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(!supply_ok),
    .take(pwr_valid && creep_ok && supply_ok), .sample(pwr_data),
    .allow(creep_ok && supply_ok && !cal_pulse), .thr(thr),
    .issue(issue), .issue_neg(issue_neg)
  );

  cal_width #(.WIDE_CYC(WIDE_CYC), .HS_CYC(HS_CYC)) u_wid (
    .clk(clk), .rst_n(rst_n), .clr(!supply_ok), .issue(issue),
    .issue_neg(issue_neg), .hs_mode(hs_mode),
    .cal_pulse(cal_pulse), .rev_flag(rev_flag)
  );
endmodule

// File: rtl/cal_pulse_gen_chk.sv
module cal_pulse_gen_chk #(
  parameter int WIDE_CYC = 9000
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic creep_ok,
  input logic cal_pulse,
  input logic rev_flag
);
  logic [31:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_len <= '0;
    else if (cal_pulse) hi_len <= hi_len + 32'd1;
    else                hi_len <= '0;
  end

  a_r7_supply_kill: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!cal_pulse && !rev_flag));

  a_r8_rise_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_pulse) |-> ($past(creep_ok) && $past(supply_ok)));

  a_r3_rev_moves_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && $past(supply_ok) && (rev_flag != $past(rev_flag))) |-> $rose(cal_pulse));

  a_r4_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pulse |-> (hi_len < 32'(WIDE_CYC)));
endmodule

bind cal_pulse_gen cal_pulse_gen_chk #(.WIDE_CYC(WIDE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .creep_ok(creep_ok),
  .cal_pulse(cal_pulse), .rev_flag(rev_flag)
);

// File: tb/cal_pulse_gen_tb.sv
module cal_pulse_gen_tb;
  localparam int DATA_W = 16, ACC_W = 24, BASE_THR = 4096, CLK_HZ = 40000;
  localparam int WIDE = CLK_HZ / 1000 * 90;
  localparam int HS = 1;
  localparam int SAT = 2 * WIDE;

  logic clk = 0, rst_n = 0;
  logic [DATA_W-1:0] pwr_data = '0;
  logic pwr_valid = 0, scale_sel = 1, supply_ok = 1, creep_ok = 1;
  logic [1:0] rate_sel = 2'b00;
  wire pwr_ready, cal_pulse, rev_flag;

  cal_pulse_gen #(.DATA_W(DATA_W), .ACC_W(ACC_W), .BASE_THR(BASE_THR), .CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_data(pwr_data), .pwr_valid(pwr_valid),
    .pwr_ready(pwr_ready), .rate_sel(rate_sel), .scale_sel(scale_sel),
    .supply_ok(supply_ok), .creep_ok(creep_ok), .cal_pulse(cal_pulse), .rev_flag(rev_flag)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R0";
  bit done = 0;

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int thr_of(logic sc, logic [1:0] r);
    int sh, t;
    case ({sc, r})
      3'b100: sh = 7;  3'b000: sh = 6;  3'b101: sh = 6;  3'b001: sh = 5;
      3'b110: sh = 5;  3'b010: sh = 4;  3'b111: sh = 4;  default: sh = 11;
    endcase
    t = BASE_THR >> sh;
    return (t == 0) ? 1 : t;
  endfunction

  // behavioural reference, stepped on every rising edge
  int m_acc = 0, m_per = SAT, m_rem = 0;
  bit m_pulse = 0, m_rev = 0;
  always @(posedge clk) begin
    int t, w;
    bit pos, neg, iss;
    if (!rst_n || !supply_ok) begin
      m_acc = 0; m_per = SAT; m_rem = 0; m_pulse = 0; m_rev = 0;
    end else begin
      t = thr_of(scale_sel, rate_sel);
      pos = creep_ok && !m_pulse && (m_acc >= t);
      neg = creep_ok && !m_pulse && !pos && (m_acc <= -t);
      iss = pos || neg;
      if (!scale_sel && rate_sel == 2'b11) w = HS;
      else if (m_per < SAT) w = (m_per / 2 < 1) ? 1 : m_per / 2;
      else w = WIDE;
      if (iss) begin m_pulse = 1; m_rem = w - 1; m_rev = neg; end
      else if (m_pulse) begin if (m_rem == 0) m_pulse = 0; else m_rem--; end
      m_per = iss ? 1 : ((m_per < SAT) ? m_per + 1 : SAT);
      m_acc = m_acc + ((pwr_valid && creep_ok) ? int'($signed(pwr_data)) : 0)
                    - (pos ? t : 0) + (neg ? t : 0);
    end
  end

  // per-cycle compare plus pulse statistics
  int rises = 0, run_len = 0, last_w = 0, max_w = 0;
  bit prev_p = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, cal_pulse, m_pulse, "cal_pulse vs model");
      chk(cur_req, rev_flag, m_rev, "rev_flag vs model");
      if (cal_pulse && !prev_p) rises++;
      if (cal_pulse) run_len++;
      else if (prev_p) begin
        last_w = run_len;
        if (run_len > max_w) max_w = run_len;
        run_len = 0;
      end
      prev_p = cal_pulse;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int v, int gap);
    pwr_data = DATA_W'(v); pwr_valid = 1;
    @(negedge clk);
    pwr_valid = 0;
    idle(gap);
  endtask

  task automatic clear_stats();
    rises = 0; max_w = 0; last_w = 0;
  endtask

  initial begin
    #200000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    chk("R0", cal_pulse, 0, "reset pulse");
    chk("R0", rev_flag, 0, "reset rev");
    chk("R0", pwr_ready, 1, "ready");
    rst_n = 1;
    idle(2);

    // R4: lone crossing after reset gives the long width (thr 32)
    cur_req = "R4"; clear_stats();
    send(32, 4000);
    chk("R4", rises, 1, "pulse count");
    chk("R4", last_w, WIDE, "long width");

    // R5: spacing 5000 gives half-period width
    cur_req = "R5"; clear_stats();
    for (int i = 0; i < 3; i++) send(32, 4999);
    idle(100);
    chk("R5", rises, 3, "pulse count");
    chk("R5", last_w, 2500, "half-period width");

    // R9: one sample worth three thresholds, held crossings drain
    cur_req = "R9"; clear_stats();
    idle(8000);
    send(96, 7000);
    chk("R9", rises, 3, "held crossings issued");
    chk("R9", last_w, 900, "third width");

    // R6: high-speed mode, thr 2
    cur_req = "R6"; clear_stats();
    scale_sel = 0; rate_sel = 2'b11;
    for (int i = 0; i < 20; i++) send(2, 9);
    idle(50);
    chk("R6", rises, 20, "pulse count");
    chk("R6", max_w, HS, "fixed short width");

    // R1: code 000 -> thr 64, sum 1000 -> 15 pulses, residual 40
    cur_req = "R1"; clear_stats();
    scale_sel = 0; rate_sel = 2'b00;
    for (int i = 0; i < 50; i++) send(20, 2);
    idle(9000);
    chk("R1", rises, 15, "thr 64 count");
    chk("R1", rev_flag, 0, "positive rev");
    // code 111 -> thr 256, 40 + 1000 -> 4 pulses, residual 16
    clear_stats();
    scale_sel = 1; rate_sel = 2'b11;
    for (int i = 0; i < 10; i++) send(100, 2);
    idle(9000);
    chk("R1", rises, 4, "thr 256 count");

    // R2: 16 - 1000 = -984 -> 3 negative pulses, residual -216
    cur_req = "R2"; clear_stats();
    for (int i = 0; i < 10; i++) send(-100, 2);
    idle(9000);
    chk("R2", rises, 3, "negative count");
    chk("R2", rev_flag, 1, "rev high");

    // R3: non-crossing positive keeps rev, crossing clears it
    cur_req = "R3"; clear_stats();
    send(100, 20);
    chk("R3", rev_flag, 1, "rev held without pulse");
    chk("R3", rises, 0, "no pulse");
    send(400, 10);
    chk("R3", rev_flag, 0, "rev cleared by positive pulse");
    chk("R3", rises, 1, "one pulse");
    idle(4000);

    // R7: 28 + 480 = 508 -> pulse, residual 252; kill supply mid-pulse
    cur_req = "R7"; clear_stats();
    send(480, 20);
    chk("R7", cal_pulse, 1, "pulse in progress");
    supply_ok = 0;
    idle(1);
    chk("R7", cal_pulse, 0, "pulse dropped");
    chk("R7", rev_flag, 0, "rev cleared");
    supply_ok = 1;
    idle(2);
    clear_stats();
    send(10, 50);
    chk("R7", rises, 0, "accumulator was cleared");

    // R8: creep gate, acc stays 10
    cur_req = "R8"; clear_stats();
    creep_ok = 0;
    for (int i = 0; i < 5; i++) send(1000, 3);
    idle(20);
    chk("R8", rises, 0, "no pulse while gated");
    creep_ok = 1;
    idle(20);
    chk("R8", rises, 0, "gated samples dropped");
    send(246, 20);
    chk("R8", rises, 1, "acc kept through gate");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule